// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps one shift register of recent outcomes that all branches share, and a table of 2-bit saturating counters. Each fetch PC is combined with the shared history to pick one counter. The counter's upper bit is the predicted direction. A build-time parameter chooses how the index is formed: from the history alone, from the history XORed with PC bits, or from history bits placed beside PC bits.

The prediction side is purely combinational. It reports the direction, the table index it used and the counter value it read, and the pipeline carries these with the branch. When the branch resolves, the update side gets back that index and counter together with the real outcome and an is-branch flag. The counter is then stepped toward the outcome and rewritten at that index, and the outcome is shifted into the shared history. The history changes only at resolve time, so it is not updated speculatively.

Top module: `ghp_predictor`

## Requirements
- R1: While reset is held, and at the first edge after it, the shared history is all zeros and every counter holds INIT_CTR (default 0). With the defaults, the prediction side reports counter 0 and not taken.
- R2: `pred_taken` is 1 exactly when `pred_ctr` is 2 or 3.
- R3: When `upd_valid` is 1, the entry at `upd_idx` becomes the carried `upd_ctr` stepped by one: plus one if `upd_taken` is 1, up to a ceiling of 3, and minus one if it is 0, down to a floor of 0. The step uses the carried value and ignores what the table currently holds.
- R4: When `upd_valid` is 1, the history shifts left by one and `upd_taken` enters at bit 0, so bit 0 is always the newest outcome. A 1 means taken.
- R5: With MODE 0, `pred_idx` equals the history register, which is IDX_W bits wide.
- R6: With MODE 1, `pred_idx` equals the IDX_W-bit history XORed with `pred_pc[ALIGN +: IDX_W]`.
- R7: With MODE 2, the history is IDX_W/2 bits wide. `pred_idx` has the history in its upper half and `pred_pc[ALIGN +: IDX_W-IDX_W/2]` in its lower bits.
- R8: When `upd_valid` is 0, the history and the counter table both stay unchanged, whatever the other update inputs carry.
- R9: If a prediction and an update fall in the same cycle, the prediction uses the table and history as they were before that update. The update becomes visible from the next cycle on.
- R10: `pred_ctr` is the counter currently stored at `pred_idx`.
- R11: With MODE 0 and a 4-bit history, a single branch that repeats the pattern taken, taken, taken, not taken will, once trained, be predicted not taken at history 4'b0111 and taken at the other three points of the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Fetch address being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | IDX_W | Table index used, to be carried to resolve |
| pred_ctr | output | 2 | Counter value read, to be carried to resolve |
| upd_valid | input | 1 | Resolved instruction is a branch; enables the update |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_idx | input | IDX_W | Index carried from prediction |
| upd_ctr | input | 2 | Counter carried from prediction |

## Verification
A prediction for a new fetch and the resolve-time update of an older branch can happen in the same cycle, sometimes at the same table index. The bench drives both sides together on every cycle of a long pseudo-random sweep. It also sets up cases where the update index equals the prediction index. In the cycle of the update, the reported counter must still hold the old value, and one cycle later it must read back the stepped value.

// File: rtl/ghp_pkg.sv
package ghp_pkg;

    // index formation variants
    localparam int MODE_GLOBAL = 0;
    localparam int MODE_XOR    = 1;
    localparam int MODE_CONCAT = 2;

    // width of the shared history for a given index width and mode
    function automatic int hist_width(input int idx_w, input int mode);
        return (mode == MODE_CONCAT) ? (idx_w / 2) : idx_w;
    endfunction

    // saturating step of a 2-bit counter toward the resolved outcome
    function automatic logic [1:0] ctr_step(input logic [1:0] ctr, input logic taken);
        logic [1:0] nxt;
        if (taken) nxt = (ctr == 2'd3) ? 2'd3 : ctr + 2'd1;
        else       nxt = (ctr == 2'd0) ? 2'd0 : ctr - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/ghp_history.sv
module ghp_history #(
    parameter int HIST_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);

    typedef struct packed {
        logic [HIST_W-1:0] ghr;
    } hist_state_t;

    hist_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (shift_en) begin
            state_d.ghr = {state_q.ghr, bit_in} >> 0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign hist = state_q.ghr;

endmodule

// File: rtl/ghp_index_hash.sv
module ghp_index_hash #(
    parameter int IDX_W  = 12,
    parameter int HIST_W = 12,
    parameter int PC_W   = 32,
    parameter int ALIGN  = 2,
    parameter int MODE   = 1
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    import ghp_pkg::*;

    localparam int PCB_W = (MODE == MODE_CONCAT) ? (IDX_W - HIST_W) : IDX_W;

    logic [PCB_W-1:0] pc_bits;
    assign pc_bits = pc[ALIGN +: PCB_W];

    generate
        if (MODE == MODE_GLOBAL) begin : g_global
            assign idx = hist;
        end else if (MODE == MODE_XOR) begin : g_xor
            assign idx = hist ^ pc_bits;
        end else begin : g_concat
            assign idx = {hist, pc_bits};
        end
    endgenerate

endmodule

// File: rtl/ghp_pattern_table.sv
module ghp_pattern_table #(
    parameter int         IDX_W    = 12,
    parameter logic [1:0] INIT_CTR = 2'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_val
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][1:0] ctr;
    } table_state_t;

    table_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.ctr[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '{ctr: {DEPTH{INIT_CTR}}};
        else        state_q <= state_d;
    end

    // read returns the registered contents: same-cycle writes are not bypassed
    assign rd_ctr = state_q.ctr[rd_idx];

endmodule

// File: rtl/ghp_predictor.sv
module ghp_predictor #(
    parameter int         IDX_W    = 12,
    parameter int         PC_W     = 32,
    parameter int         ALIGN    = 2,
    parameter int         MODE     = 1,
    parameter logic [1:0] INIT_CTR = 2'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pred_pc,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_idx,
    output logic [1:0]       pred_ctr,
    input  logic             upd_valid,
    input  logic             upd_taken,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [1:0]       upd_ctr
);
    import ghp_pkg::*;

    localparam int HIST_W = hist_width(IDX_W, MODE);

    logic [HIST_W-1:0] hist_q;
    logic [1:0]        new_ctr;

    ghp_history #(.HIST_W(HIST_W)) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist     (hist_q)
    );

    ghp_index_hash #(
        .IDX_W (IDX_W), .HIST_W(HIST_W), .PC_W(PC_W), .ALIGN(ALIGN), .MODE(MODE)
    ) hash_i (
        .pc   (pred_pc),
        .hist (hist_q),
        .idx  (pred_idx)
    );

    assign new_ctr = ctr_step(upd_ctr, upd_taken);

    ghp_pattern_table #(.IDX_W(IDX_W), .INIT_CTR(INIT_CTR)) pht_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (pred_idx),
        .rd_ctr (pred_ctr),
        .wr_en  (upd_valid),
        .wr_idx (upd_idx),
        .wr_val (new_ctr)
    );

    assign pred_taken = pred_ctr[1];

endmodule

// File: rtl/ghp_checker.sv
module ghp_checker #(
    parameter int IDX_W  = 12,
    parameter int HIST_W = 12,
    parameter int PC_W   = 32,
    parameter int ALIGN  = 2,
    parameter int MODE   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   pred_pc,
    input logic [IDX_W-1:0]  pred_idx,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [HIST_W-1:0] ghr
);

    // R1: history is clear at the first edge out of reset
    p_hist_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ghr == '0));

    // R4: a resolved branch shifts its outcome into bit 0
    p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghr == HIST_W'({$past(ghr), $past(upd_taken)})));

    // R8: no branch resolved, history untouched
    p_hist_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghr));

    generate
        if (MODE == 0) begin : g_chk_global
            p_idx_global_r5: assert property (@(posedge clk) disable iff (!rst_n)
                pred_idx == ghr);
        end else if (MODE == 1) begin : g_chk_xor
            p_idx_xor_r6: assert property (@(posedge clk) disable iff (!rst_n)
                pred_idx == (ghr ^ pred_pc[ALIGN +: IDX_W]));
        end else begin : g_chk_concat
            p_idx_concat_r7: assert property (@(posedge clk) disable iff (!rst_n)
                pred_idx[IDX_W-1 -: HIST_W] == ghr);
        end
    endgenerate

endmodule

bind ghp_predictor ghp_checker #(
    .IDX_W(IDX_W), .HIST_W(HIST_W), .PC_W(PC_W), .ALIGN(ALIGN), .MODE(MODE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pred_pc   (pred_pc),
    .pred_idx  (pred_idx),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .ghr       (hist_q)
);

// File: tb/ghp_predictor_tb_top.sv
`timescale 1ns/1ps
module ghp_predictor_tb_top;

    localparam int IW = 4;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] pc = '0;
    logic          uv = 1'b0;
    logic          ut = 1'b0;
    logic [IW-1:0] ui = '0;
    logic [1:0]    uc = '0;

    logic          tk_x, tk_g, tk_s;
    logic [IW-1:0] ix_x, ix_g, ix_s;
    logic [1:0]    ct_x, ct_g, ct_s;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model: identical update stream reaches all three instances
    logic [1:0]    mtab [16];
    logic [IW-1:0] mghr;

    always #4 clk = ~clk;

    ghp_predictor #(.IDX_W(IW), .PC_W(PW), .ALIGN(2), .MODE(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .pred_pc(pc), .pred_taken(tk_x), .pred_idx(ix_x),
        .pred_ctr(ct_x), .upd_valid(uv), .upd_taken(ut), .upd_idx(ui), .upd_ctr(uc));

    ghp_predictor #(.IDX_W(IW), .PC_W(PW), .ALIGN(2), .MODE(0)) dut_gag_i (
        .clk(clk), .rst_n(rst_n), .pred_pc(pc), .pred_taken(tk_g), .pred_idx(ix_g),
        .pred_ctr(ct_g), .upd_valid(uv), .upd_taken(ut), .upd_idx(ui), .upd_ctr(uc));

    ghp_predictor #(.IDX_W(IW), .PC_W(PW), .ALIGN(2), .MODE(2)) dut_sel_i (
        .clk(clk), .rst_n(rst_n), .pred_pc(pc), .pred_taken(tk_s), .pred_idx(ix_s),
        .pred_ctr(ct_s), .upd_valid(uv), .upd_taken(ut), .upd_idx(ui), .upd_ctr(uc));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] step(input logic [1:0] c, input logic t);
        if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    function automatic logic [IW-1:0] xidx(input logic [PW-1:0] p);
        return mghr ^ p[5:2];
    endfunction

    task automatic drive(input logic [PW-1:0] p, input logic v, input logic t,
                         input logic [IW-1:0] i, input logic [1:0] c);
        @(negedge clk);
        pc = p; uv = v; ut = t; ui = i; uc = c;
        #1;
    endtask

    task automatic compare_all();
        logic [IW-1:0] eg, ex, es;
        eg = mghr;
        ex = xidx(pc);
        es = {mghr[1:0], pc[3:2]};
        chk(ix_g == eg, "R5 global index", ix_g, eg);
        chk(ix_x == ex, "R6 xor index", ix_x, ex);
        chk(ix_s == es, "R7 concat index", ix_s, es);
        chk(ct_g == mtab[eg], "R10 global ctr", ct_g, mtab[eg]);
        chk(ct_x == mtab[ex], "R10 xor ctr", ct_x, mtab[ex]);
        chk(ct_s == mtab[es], "R10 concat ctr", ct_s, mtab[es]);
        chk(tk_x == (mtab[ex] >= 2), "R2 direction", tk_x, mtab[ex] >= 2);
        chk(tk_g == (mtab[eg] >= 2), "R2 direction", tk_g, mtab[eg] >= 2);
    endtask

    task automatic commit();
        @(posedge clk);
        if (uv) begin
            mtab[ui] = step(uc, ut);
            mghr = {mghr[IW-2:0], ut};
        end
    endtask

    task automatic cycle(input logic [PW-1:0] p, input logic v, input logic t,
                         input logic [IW-1:0] i, input logic [1:0] c);
        drive(p, v, t, i, c);
        compare_all();
        commit();
    endtask

    // pc that makes the xor instance look at index tgt
    function automatic logic [PW-1:0] pc_for(input logic [IW-1:0] tgt);
        return PW'({tgt ^ mghr, 2'b00});
    endfunction

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [IW-1:0] g0;
        logic [1:0]    old;
        for (int k = 0; k < 16; k++) mtab[k] = 2'd0;
        mghr = '0;
        lfsr = 16'hACE1;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(ct_x == 0 && ct_g == 0 && ct_s == 0, "R1 reset ctr", ct_x, 0);
        chk(tk_x == 0, "R1 reset direction", tk_x, 0);
        chk(ix_g == 0, "R1 reset history", ix_g, 0);
        @(negedge clk); rst_n = 1'b1;

        // pseudo-random sweep: predictions and updates every cycle (R2, R4..R10)
        for (int n = 0; n < 800; n++) begin
            logic [IW-1:0] i;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            i = lfsr[9:6];
            cycle(lfsr, lfsr[0] | lfsr[3], lfsr[1], i, lfsr[0] ? mtab[i] : lfsr[5:4]);
        end

        // R3: every carried counter with both outcomes, read back next cycle
        for (int c = 0; c < 4; c++) begin
            for (int t = 0; t < 2; t++) begin
                cycle(pc_for(4'd9), 1'b1, t[0], 4'd9, c[1:0]);
                drive(pc_for(4'd9), 1'b0, 1'b0, 4'd0, 2'd0);
                chk(ct_x == step(c[1:0], t[0]), "R3 saturating step", ct_x, step(c[1:0], t[0]));
                compare_all();
                commit();
            end
        end

        // R9: same-cycle prediction and update at the same index
        drive(pc_for(4'd5), 1'b1, 1'b1, 4'd5, 2'd2);
        old = mtab[5];
        chk(ct_x == old, "R9 old value in update cycle", ct_x, old);
        commit();
        drive(pc_for(4'd5), 1'b0, 1'b0, 4'd0, 2'd0);
        chk(ct_x == 2'd3, "R9 new value next cycle", ct_x, 3);
        commit();

        // R8: update inputs active but valid low
        g0 = mghr;
        old = mtab[5];
        cycle(pc_for(4'd3), 1'b0, 1'b1, 4'd5, 2'd3);
        drive(pc_for(4'd5), 1'b0, 1'b0, 4'd0, 2'd0);
        chk(ct_x == old, "R8 table unchanged", ct_x, old);
        chk(ix_g == g0, "R8 history unchanged", ix_g, g0);
        commit();

        // R11: TTTN loop learned by the history-only instance
        for (int it = 0; it < 12; it++) begin
            for (int k = 0; k < 4; k++) begin
                logic t;
                t = (k != 3);
                drive(16'h0040, 1'b1, t, mghr, mtab[mghr]);
                compare_all();
                if (it >= 8) begin
                    if (k == 3) begin
                        chk(ix_g == 4'b0111, "R11 history before exit", ix_g, 7);
                        chk(tk_g == 1'b0, "R11 exit predicted not taken", tk_g, 0);
                    end else begin
                        chk(tk_g == 1'b1, "R11 body predicted taken", tk_g, 1);
                    end
                end
                commit();
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule